// File: doc/BRIEF.md
# Isochronous Cycle Timer Unit

This block keeps the two-field cycle timer of a serial-bus link: a sub-cycle `cycle_offset` counter and a `cycle_count` counter that advances once per isochronous cycle. The cycle count can advance in one of two ways. With the external-source control low, it steps when the offset counter wraps. With that control high, it steps on each rising edge of an asynchronous cycle input, and that edge also returns the offset to zero. In external mode the offset never wraps by itself. Instead it parks at its top value until the next edge arrives.

On every advance of the cycle count, the block can raise two one-cycle strobes. The first is a request to transmit a cycle-start packet, raised only when the node is cycle master and attached to the root. The second is an end-of-cycle mark, raised only when marking is enabled. All control bits are plain level inputs held by the surrounding register logic. In particular, the cycle-master bit is never altered by this block. Packet formatting and the PHY lie outside the block.

A small phase machine chooses the offset action every cycle. It has four states:
- PH_STOP: internal mode with the timer disabled.
- PH_FREE: internal mode, counting.
- PH_SLAVE: external mode with the offset below its top.
- PH_PARK: external mode with the offset at its top.

The next phase depends only on the source select, the enable and whether the offset is at its top. The machine therefore moves between PH_STOP and PH_FREE when the enable toggles, and between either of those and PH_SLAVE or PH_PARK when the source select toggles. It moves from PH_SLAVE to PH_PARK when the offset reaches its top. It moves from PH_PARK back to PH_SLAVE after an external edge clears the offset.

Top module: `cyc_timer_top`

## Requirements
- R1: After reset, cycle_offset and cycle_count are 0 and start_req and cycle_mark are low.
- R2: cycle_offset rises by exactly one per clock while timer_en is high, and holds its value while timer_en is low (except for an external edge in external mode).
- R3: With ext_src low and timer_en high, cycle_offset goes from OFFSET_MAX to 0 and cycle_count rises by one on the same clock edge. The count changes on no other edge.
- R4: cycle_count goes from COUNT_MAX to 0 on its next advance.
- R5: With ext_src high, a rising edge on cycle_in passes a two-flop synchronizer and an edge detector. The count is then one higher and the offset is 0 after the third rising clock edge that follows the input change, whether or not timer_en is high.
- R6: With ext_src high, cycle_offset stops at OFFSET_MAX and does not wrap, and cycle_count does not change, until an external edge arrives.
- R7: Each rising edge of cycle_in advances the count exactly once in external mode. Holding cycle_in high or dropping it has no further effect on the count.
- R8: start_req is a one-cycle pulse, seen together with the new count value, on each count advance while both cyc_master and at_root are high. It stays low when either is low.
- R9: cycle_mark is a one-cycle pulse, seen together with the new count value, on each count advance while mark_en is high. It stays low when mark_en is low.
- R10: With ext_src low, activity on cycle_in leaves cycle_count and cycle_offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_en | input | 1 | Lets the offset counter advance |
| ext_src | input | 1 | 1: cycle_in edges drive the count; 0: offset wrap drives it |
| cyc_master | input | 1 | Node acts as cycle master |
| at_root | input | 1 | Node is attached to the root |
| mark_en | input | 1 | Enables the end-of-cycle mark strobe |
| cycle_in | input | 1 | Asynchronous external cycle input |
| cycle_offset | output | OFF_W (12) | Sub-cycle offset counter |
| cycle_count | output | CNT_W (13) | Cycle counter |
| start_req | output | 1 | One-cycle request to send a cycle-start packet |
| cycle_mark | output | 1 | One-cycle end-of-cycle mark |

## Verification
The bench targets the boundary where the offset sits at its top.

| Corner case | How a faulty design shows it |
|---|---|
| Offset at its top in internal mode | A design that wraps late or forgets the count step shows a count that lags the offset. |
| Offset at its top in external mode | A design that wraps anyway shows an offset near zero and an extra count step with no edge. |
| Synchronizer latency | A missing synchronizer flop moves the count one clock early. |
| cycle_in held high | A level-sensitive design instead of an edge-sensitive one keeps counting. |
| Count wrap and strobe gating | A wrong wrap limit, or strobes gated on the wrong condition, shows up as a wrong count after many cycles or as stray start or mark pulses while the node is not at the root or marking is off. |

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    // Phase of the offset counter's controlling machine
    typedef enum logic [1:0] {
        PH_STOP  = 2'd0,
        PH_FREE  = 2'd1,
        PH_SLAVE = 2'd2,
        PH_PARK  = 2'd3
    } phase_e;

    // Action applied to the offset counter this cycle
    typedef enum logic [1:0] {
        OFS_HOLD = 2'd0,
        OFS_INC  = 2'd1,
        OFS_CLR  = 2'd2
    } ofs_act_e;

endpackage

// File: rtl/cyc_edge_sync.sv
module cyc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // chain[STAGES-1:0] are synchronizer flops, chain[STAGES] is the edge reference
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R7: a single input edge yields a single detector pulse
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/cyc_phase_fsm.sv
module cyc_phase_fsm
    import cyc_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     timer_en,
    input  logic     ext_src,
    input  logic     ext_rise,
    input  logic     off_at_max,
    output ofs_act_e act,
    output logic     step
);
    phase_e phase_q;
    phase_e phase_d;

    // Next-state selection
    always_comb begin
        if (ext_src) begin
            phase_d = off_at_max ? PH_PARK : PH_SLAVE;
        end else begin
            phase_d = timer_en ? PH_FREE : PH_STOP;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STOP;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Output decode for the phase in force this cycle
    always_comb begin
        act  = OFS_HOLD;
        step = 1'b0;
        unique case (phase_d)
            PH_STOP: begin
                act = OFS_HOLD;
            end
            PH_FREE: begin
                if (off_at_max) begin
                    act  = OFS_CLR;
                    step = 1'b1;
                end else begin
                    act = OFS_INC;
                end
            end
            PH_SLAVE: begin
                if (ext_rise) begin
                    act  = OFS_CLR;
                    step = 1'b1;
                end else if (timer_en) begin
                    act = OFS_INC;
                end
            end
            PH_PARK: begin
                if (ext_rise) begin
                    act  = OFS_CLR;
                    step = 1'b1;
                end
            end
            default: begin
                act  = OFS_HOLD;
                step = 1'b0;
            end
        endcase
    end

    // R6: a parked phase not left by an edge still sees the offset at its top
    a_r6_park_stays_top: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PARK && !$past(ext_rise) && ext_src) |-> off_at_max);

endmodule

// File: rtl/cyc_offset_ctr.sv
module cyc_offset_ctr
    import cyc_timer_pkg::*;
#(
    parameter int OFFSET_MAX = 3071,
    parameter int OFF_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ofs_act_e         act,
    output logic [OFF_W-1:0] offset,
    output logic             at_max
);
    localparam logic [OFF_W-1:0] OFS_TOP = OFF_W'(OFFSET_MAX);

    logic [OFF_W-1:0] offset_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else begin
            unique case (act)
                OFS_INC:  offset_q <= offset_q + 1'b1;
                OFS_CLR:  offset_q <= '0;
                default:  offset_q <= offset_q;
            endcase
        end
    end

    assign offset = offset_q;
    assign at_max = (offset_q == OFS_TOP);

    // R2: the offset never exceeds its top value
    a_r2_offset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        offset_q <= OFS_TOP);

endmodule

// File: rtl/cyc_count_ctr.sv
module cyc_count_ctr #(
    parameter int COUNT_MAX = 7999,
    parameter int CNT_W     = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             send_ok,
    input  logic             mark_en,
    output logic [CNT_W-1:0] count,
    output logic             start_req,
    output logic             cycle_mark
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(COUNT_MAX);

    logic [CNT_W-1:0] count_q;
    logic             start_q;
    logic             mark_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            start_q <= 1'b0;
            mark_q  <= 1'b0;
        end else begin
            if (step) begin
                count_q <= (count_q == CNT_TOP) ? '0 : count_q + 1'b1;
            end
            start_q <= step & send_ok;
            mark_q  <= step & mark_en;
        end
    end

    assign count      = count_q;
    assign start_req  = start_q;
    assign cycle_mark = mark_q;

    // R3: the count moves only on a step
    a_r3_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count_q));
    // R4: the count stays inside its range
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_TOP);
    // R8: start request lasts one cycle
    a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R9: mark lasts one cycle
    a_r9_mark_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mark_q |=> !mark_q);

endmodule

// File: rtl/cyc_timer_top.sv
module cyc_timer_top
    import cyc_timer_pkg::*;
#(
    parameter int OFFSET_MAX  = 3071,
    parameter int COUNT_MAX   = 7999,
    parameter int OFF_W       = 12,
    parameter int CNT_W       = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_en,
    input  logic             ext_src,
    input  logic             cyc_master,
    input  logic             at_root,
    input  logic             mark_en,
    input  logic             cycle_in,
    output logic [OFF_W-1:0] cycle_offset,
    output logic [CNT_W-1:0] cycle_count,
    output logic             start_req,
    output logic             cycle_mark
);
    localparam logic [OFF_W-1:0] OFS_TOP = OFF_W'(OFFSET_MAX);

    logic     ext_rise;
    logic     off_at_max;
    logic     step;
    ofs_act_e act;

    cyc_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cycle_in),
        .rise     (ext_rise)
    );

    cyc_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .timer_en   (timer_en),
        .ext_src    (ext_src),
        .ext_rise   (ext_rise),
        .off_at_max (off_at_max),
        .act        (act),
        .step       (step)
    );

    cyc_offset_ctr #(
        .OFFSET_MAX (OFFSET_MAX),
        .OFF_W      (OFF_W)
    ) u_ofs (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .offset (cycle_offset),
        .at_max (off_at_max)
    );

    cyc_count_ctr #(
        .COUNT_MAX (COUNT_MAX),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .send_ok    (cyc_master & at_root),
        .mark_en    (mark_en),
        .count      (cycle_count),
        .start_req  (start_req),
        .cycle_mark (cycle_mark)
    );

    // R2: a disabled timer holds its offset unless an external edge clears it
    a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_en && !(ext_src && ext_rise)) |=> $stable(cycle_offset));
    // R3: internal wrap of the offset steps the count
    a_r3_wrap_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_src && timer_en && cycle_offset == OFS_TOP)
        |=> (cycle_offset == '0 && cycle_count != $past(cycle_count)));
    // R5: an external edge in external mode clears the offset
    a_r5_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_src && ext_rise) |=> (cycle_offset == '0));
    // R6: in external mode the offset parks at its top
    a_r6_no_self_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_src && !ext_rise && cycle_offset == OFS_TOP)
        |=> (cycle_offset == OFS_TOP && $stable(cycle_count)));

endmodule

// File: tb/cyc_timer_top_tb.sv
module cyc_timer_top_tb;
    localparam int OMAX = 15;
    localparam int CMAX = 9;
    localparam int PER  = OMAX + 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        timer_en, ext_src, cyc_master, at_root, mark_en, cycle_in;
    logic [11:0] cycle_offset;
    logic [12:0] cycle_count;
    logic        start_req, cycle_mark;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cyc_timer_top #(
        .OFFSET_MAX (OMAX),
        .COUNT_MAX  (CMAX)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .timer_en     (timer_en),
        .ext_src      (ext_src),
        .cyc_master   (cyc_master),
        .at_root      (at_root),
        .mark_en      (mark_en),
        .cycle_in     (cycle_in),
        .cycle_offset (cycle_offset),
        .cycle_count  (cycle_count),
        .start_req    (start_req),
        .cycle_mark   (cycle_mark)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Ticks n cycles, accumulating observed strobes
    task automatic tick_count(input int n, inout int starts, inout int marks);
        repeat (n) begin
            @(posedge clk);
            #1;
            starts += int'(start_req);
            marks  += int'(cycle_mark);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        timer_en = 0; ext_src = 0; cyc_master = 0; at_root = 0; mark_en = 0; cycle_in = 0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 offset", int'(cycle_offset), 0);
        check("R1 count", int'(cycle_count), 0);
        check("R1 start_req", int'(start_req), 0);
        check("R1 cycle_mark", int'(cycle_mark), 0);
        tick(3);
        check("R2 idle offset", int'(cycle_offset), 0);
    endtask

    task automatic t_internal();
        do_reset();
        timer_en = 1; mark_en = 1;
        tick(1);
        check("R2 offset step", int'(cycle_offset), 1);
        tick(OMAX - 1);
        check("R3 offset at top", int'(cycle_offset), OMAX);
        check("R3 count before wrap", int'(cycle_count), 0);
        check("R9 no early mark", int'(cycle_mark), 0);
        tick(1);
        check("R3 offset wrapped", int'(cycle_offset), 0);
        check("R3 count stepped", int'(cycle_count), 1);
        check("R9 mark on step", int'(cycle_mark), 1);
        check("R8 no start without master", int'(start_req), 0);
        tick(1);
        check("R9 mark single", int'(cycle_mark), 0);
        check("R2 offset after wrap", int'(cycle_offset), 1);
    endtask

    task automatic t_disable();
        do_reset();
        timer_en = 1;
        tick(5);
        timer_en = 0;
        tick(10);
        check("R2 hold offset", int'(cycle_offset), 5);
        check("R2 hold count", int'(cycle_count), 0);
        timer_en = 1;
        tick(1);
        check("R2 resume", int'(cycle_offset), 6);
    endtask

    task automatic t_count_wrap();
        int s = 0;
        int m = 0;
        do_reset();
        timer_en = 1; cyc_master = 1; at_root = 1;
        tick_count(PER * CMAX, s, m);
        check("R4 count at top", int'(cycle_count), CMAX);
        check("R8 starts per step", s, CMAX);
        tick_count(PER, s, m);
        check("R4 count wrapped", int'(cycle_count), 0);
        check("R8 start at wrap", int'(start_req), 1);
        check("R8 total starts", s, CMAX + 1);
        check("R9 no marks when disabled", m, 0);
    endtask

    task automatic t_not_root();
        int s = 0;
        int m = 0;
        do_reset();
        timer_en = 1; cyc_master = 1; at_root = 0; mark_en = 1;
        tick_count(PER * 3, s, m);
        check("R8 no start off root", s, 0);
        check("R9 marks counted", m, 3);
        check("R3 count after three", int'(cycle_count), 3);
    endtask

    task automatic t_external();
        do_reset();
        ext_src = 1; timer_en = 1; cyc_master = 1; at_root = 1;
        tick(5);
        check("R2 ext offset runs", int'(cycle_offset), 5);
        cycle_in = 1;
        tick(2);
        check("R5 not yet offset", int'(cycle_offset), 7);
        check("R5 not yet count", int'(cycle_count), 0);
        check("R8 no early start", int'(start_req), 0);
        tick(1);
        check("R5 offset cleared", int'(cycle_offset), 0);
        check("R5 count stepped", int'(cycle_count), 1);
        check("R8 start on ext step", int'(start_req), 1);
        tick(1);
        check("R8 start single", int'(start_req), 0);
        tick(9);
        check("R7 level high no step", int'(cycle_count), 1);
        check("R7 offset keeps running", int'(cycle_offset), 10);
        cycle_in = 0;
        tick(5);
        check("R7 falling edge no step", int'(cycle_count), 1);
        // Two edges in quick succession
        cycle_in = 1; tick(2);
        cycle_in = 0; tick(2);
        cycle_in = 1; tick(3);
        check("R5 two edges two steps", int'(cycle_count), 3);
        cycle_in = 0;
        tick(3);
    endtask

    task automatic t_park();
        do_reset();
        ext_src = 1; timer_en = 1;
        tick(OMAX);
        check("R6 reached top", int'(cycle_offset), OMAX);
        tick(20);
        check("R6 parked offset", int'(cycle_offset), OMAX);
        check("R6 no self step", int'(cycle_count), 0);
        cycle_in = 1;
        tick(3);
        check("R6 edge releases offset", int'(cycle_offset), 0);
        check("R6 edge steps count", int'(cycle_count), 1);
        cycle_in = 0;
    endtask

    task automatic t_ext_disabled();
        do_reset();
        ext_src = 1; timer_en = 0;
        tick(2);
        cycle_in = 1; tick(1);
        cycle_in = 0; tick(2);
        check("R5 step with timer off", int'(cycle_count), 1);
        check("R5 offset zero timer off", int'(cycle_offset), 0);
        tick(5);
        check("R5 stays after edge", int'(cycle_count), 1);
    endtask

    task automatic t_int_ignore();
        do_reset();
        ext_src = 0; timer_en = 0;
        for (int i = 0; i < 4; i++) begin
            cycle_in = 1; tick(4);
            cycle_in = 0; tick(4);
        end
        check("R10 count ignores input", int'(cycle_count), 0);
        check("R10 offset ignores input", int'(cycle_offset), 0);
    endtask

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_internal();
        t_disable();
        t_count_wrap();
        t_not_root();
        t_external();
        t_park();
        t_ext_disabled();
        t_int_ignore();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule